// File: doc/BRIEF.md
# Buffered Sequential Matrix Multiplier

This block forms the product of two square matrices of unsigned integers through one multiply-accumulate unit. The operand elements come in one at a time on a valid-qualified input. The first N*N accepted elements fill the buffer for the left operand A. The next N*N accepted elements fill the buffer for the right operand B. Within each matrix the elements arrive row by row, and within a row column by column.

Once the last element of B has been stored, a controller walks three nested counters (result row, result column, dot-product term) and reads one element from each operand buffer per cycle. The multiply-accumulate unit turns each group of N products into one result element. That element goes into a result buffer at its row-major index, and the controller then raises a completion flag.

The result buffer can be read at any time through a separate address port. Each read has one cycle of latency. A new input beat that arrives after completion starts the next load.

Top module: `mmul_core`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and `rd_data` is 0.
- R2: Accepted beats are numbered from 0 from the start of a load. Beat n with n < N*N is stored as A[n/N][n%N]. Beat N*N+m is stored as B[m/N][m%N]. A cycle with `in_valid` low stores nothing and does not advance the beat count.
- R3: Every result element C[i][j] equals the sum over k of A[i][k]*B[k][j], computed as an unsigned value of 2*DW+log2(N) bits with no overflow, even when every operand is 2^DW-1. It is readable at `rd_addr` = i*N+j.
- R4: The result buffer is not written until all 2*N*N operand beats have been stored. Results from the previous run stay readable while the next load is in progress.
- R5: Input beats presented while products are being computed have no effect on the results.
- R6: `done` rises exactly N*N*N+2 clock edges after the edge that accepted the final B element. It stays high until the next accepted input beat, which clears it.
- R7: `rd_data` shows the result at the `rd_addr` sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand element valid |
| in_data | input | DW | Operand element, unsigned |
| rd_addr | input | 2*log2(N) | Result read address, row-major |
| rd_data | output | 2*DW+log2(N) | Registered result read data |
| done | output | 1 | All N*N results written |

## Verification
The bench inserts idle gaps into the operand stream. A design that advanced its load counter on idle cycles would place elements at the wrong indices and corrupt every dot product.

A run with every operand at its maximum value exposes an accumulator that is too narrow, because it would wrap. Pseudo-random operands catch swapped A/B address formulas or a transposed operand. They also catch an accumulator that is not cleared between elements, since each result would then carry its predecessor's sum.

Junk beats are injected during computation, and the previous run's results are read back mid-load. These catch a design that overwrites a buffer while computing or starts computing early. Exact edge counting of `done` catches a write that is one pipeline stage early, which would store a partial sum.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_A,
    ST_LOAD_B,
    ST_COMPUTE,
    ST_DONE
  } mm_state_e;
endpackage

// File: rtl/mmul_ram.sv
// Simple dual-port buffer: one write port, one registered read port.
module mmul_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous reset maps onto a block RAM output stage.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/mmul_mac.sv
// Multiply-accumulate: on the first term the old sum is discarded.
module mmul_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             first,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [ACC_W-1:0] acc
);
  localparam int PW = 2 * DW;

  logic [PW-1:0]    prod;
  logic [ACC_W-1:0] base;

  always_comb begin
    prod = a * b;
    base = first ? '0 : acc;
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= base + {{(ACC_W-PW){1'b0}}, prod};
  end
endmodule

// File: rtl/mmul_ctrl.sv
// Sequencer: load counting, address generation and pipeline tracking.
module mmul_ctrl
  import mmul_pkg::*;
#(
  parameter int N  = 32,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          ld_we_a,
  output logic          ld_we_b,
  output logic [AW-1:0] ld_addr,
  output logic [AW-1:0] a_raddr,
  output logic [AW-1:0] b_raddr,
  output logic          mac_en,
  output logic          mac_first,
  output logic          out_we,
  output logic [AW-1:0] out_addr,
  output logic          done,
  output mm_state_e     state
);
  mm_state_e     state_q;
  logic [AW-1:0] ld_cnt;
  logic          ld_last;
  logic          ld_b_final;

  // Issue counters: result row, result column, product term.
  logic [LN-1:0] row_q, col_q, term_q;
  logic          iss_on;

  // Stage 1: operand data from the buffers is valid this cycle.
  logic          s1_v, s1_first, s1_last;
  logic [AW-1:0] s1_idx;
  // Stage 2: accumulator holds the sum that includes the stage-1 term.
  logic          s2_v, s2_last;
  logic [AW-1:0] s2_idx;
  logic          final_wr;

  always_comb begin
    ld_last    = (ld_cnt == '1);
    ld_we_a    = in_valid && (state_q == ST_IDLE || state_q == ST_LOAD_A ||
                              state_q == ST_DONE);
    ld_we_b    = in_valid && (state_q == ST_LOAD_B);
    ld_b_final = ld_we_b && ld_last;
    ld_addr    = ld_cnt;
    a_raddr    = {row_q, term_q};
    b_raddr    = {term_q, col_q};
    mac_en     = s1_v;
    mac_first  = s1_first;
    out_we     = s2_v && s2_last;
    out_addr   = s2_idx;
    final_wr   = out_we && (s2_idx == '1);
    state      = state_q;
  end

  // Load sequencing and completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ld_cnt  <= '0;
      done    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (in_valid) begin
            state_q <= ST_LOAD_A;
            ld_cnt  <= AW'(1);
            done    <= 1'b0;
          end
        end
        ST_LOAD_A: begin
          if (in_valid) begin
            ld_cnt <= ld_cnt + AW'(1);
            if (ld_last) state_q <= ST_LOAD_B;
          end
        end
        ST_LOAD_B: begin
          if (in_valid) begin
            ld_cnt <= ld_cnt + AW'(1);
            if (ld_last) state_q <= ST_COMPUTE;
          end
        end
        ST_COMPUTE: begin
          if (final_wr) begin
            state_q <= ST_DONE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Address generation: term fastest, then column, then row.
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_on <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      term_q <= '0;
    end else if (ld_b_final) begin
      iss_on <= 1'b1;
      row_q  <= '0;
      col_q  <= '0;
      term_q <= '0;
    end else if (iss_on) begin
      term_q <= term_q + LN'(1);
      if (term_q == '1) begin
        col_q <= col_q + LN'(1);
        if (col_q == '1) begin
          row_q <= row_q + LN'(1);
          if (row_q == '1) iss_on <= 1'b0;
        end
      end
    end
  end

  // Pipeline tags: align first/last/index with buffer read latency and MAC.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
      s2_v     <= 1'b0;
      s2_last  <= 1'b0;
      s2_idx   <= '0;
    end else begin
      s1_v     <= iss_on;
      s1_first <= (term_q == '0);
      s1_last  <= (term_q == '1);
      s1_idx   <= {row_q, col_q};
      s2_v     <= s1_v;
      s2_last  <= s1_last;
      s2_idx   <= s1_idx;
    end
  end
endmodule

// File: rtl/mmul_core.sv
// Top: two operand buffers, one MAC, one result buffer, one sequencer.
module mmul_core
  import mmul_pkg::*;
#(
  parameter int N      = 32,
  parameter int DW     = 16,
  localparam int LN    = $clog2(N),
  localparam int AW    = 2 * LN,
  localparam int DEPTH = N * N,
  localparam int ACC_W = 2 * DW + LN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [ACC_W-1:0] rd_data,
  output logic             done
);
  logic          ld_we_a, ld_we_b;
  logic [AW-1:0] ld_addr;
  logic [AW-1:0] a_raddr, b_raddr;
  logic          mac_en, mac_first;
  logic          out_we;
  logic [AW-1:0] out_addr;
  mm_state_e     state;

  logic [ACC_W-1:0] acc;
  logic [1:0]       buf_we;
  logic [AW-1:0]    buf_raddr [2];
  logic [DW-1:0]    buf_rdata [2];

  always_comb begin
    buf_we[0]    = ld_we_a;
    buf_we[1]    = ld_we_b;
    buf_raddr[0] = a_raddr;
    buf_raddr[1] = b_raddr;
  end

  mmul_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .ld_we_a   (ld_we_a),
    .ld_we_b   (ld_we_b),
    .ld_addr   (ld_addr),
    .a_raddr   (a_raddr),
    .b_raddr   (b_raddr),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .out_we    (out_we),
    .out_addr  (out_addr),
    .done      (done),
    .state     (state)
  );

  // Operand buffers: index 0 holds A, index 1 holds B.
  for (genvar g = 0; g < 2; g++) begin : g_opbuf
    mmul_ram #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst   (rst),
      .we    (buf_we[g]),
      .waddr (ld_addr),
      .wdata (in_data),
      .raddr (buf_raddr[g]),
      .rdata (buf_rdata[g])
    );
  end

  mmul_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst   (rst),
    .en    (mac_en),
    .first (mac_first),
    .a     (buf_rdata[0]),
    .b     (buf_rdata[1]),
    .acc   (acc)
  );

  mmul_ram #(.DW(ACC_W), .DEPTH(DEPTH)) u_res (
    .clk   (clk),
    .rst   (rst),
    .we    (out_we),
    .waddr (out_addr),
    .wdata (acc),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/mmul_core_chk.sv
module mmul_core_chk
  import mmul_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          done,
  input mm_state_e     state,
  input logic          ld_we_a,
  input logic          ld_we_b,
  input logic          mac_en,
  input logic          out_we,
  input logic [AW-1:0] out_addr
);
  AST_ONE_BUFFER_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(ld_we_a && ld_we_b)); // R2

  AST_SPACED_RESULT_WRITES: assert property (@(posedge clk) disable iff (rst)
    out_we |=> !out_we); // R3

  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_we |-> state == ST_COMPUTE); // R4

  AST_MAC_ONLY_COMPUTE: assert property (@(posedge clk) disable iff (rst)
    mac_en |-> state == ST_COMPUTE); // R4

  AST_NO_LOAD_IN_COMPUTE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMPUTE) |-> !(ld_we_a || ld_we_b)); // R5

  AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
    (out_we && out_addr == '1) |=> done); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !in_valid) |=> done); // R6

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done && in_valid) |=> !done); // R6

  AST_DONE_STATE: assert property (@(posedge clk) disable iff (rst)
    done |-> state == ST_DONE); // R6
endmodule

bind mmul_core mmul_core_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .done     (done),
  .state    (state),
  .ld_we_a  (ld_we_a),
  .ld_we_b  (ld_we_b),
  .mac_en   (mac_en),
  .out_we   (out_we),
  .out_addr (out_addr)
);

// File: tb/mmul_core_test.sv
module mmul_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 32;
  localparam int DW    = 16;
  localparam int LN    = $clog2(N);
  localparam int AW    = 2 * LN;
  localparam int ACC_W = 2 * DW + LN;
  localparam int NN    = N * N;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [DW-1:0]    in_data = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic [ACC_W-1:0] rd_data;
  logic             done;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0]    am [NN];
  logic [DW-1:0]    bm [NN];
  logic [ACC_W-1:0] cm [NN];
  logic [ACC_W-1:0] prev_c5;
  logic [ACC_W-1:0] exp_q [$];
  logic             rd_req = 1'b0;
  logic             pend = 1'b0;
  logic [31:0]      lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmul_core #(.N(N), .DW(DW)) uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .done     (done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_rand();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr[31:16];
  endfunction

  // Driver side of the scoreboard: reference model pushes expected results.
  task automatic build(input int mode);
    for (int x = 0; x < NN; x++) begin
      am[x] = (mode == 1) ? '1 : next_rand();
      bm[x] = (mode == 1) ? '1 : next_rand();
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [63:0] s;
        s = '0;
        for (int k = 0; k < N; k++)
          s += 64'(am[i*N+k]) * 64'(bm[k*N+j]);
        cm[i*N+j] = ACC_W'(s);
        exp_q.push_back(ACC_W'(s));
      end
  endtask

  task automatic beat(input logic [DW-1:0] d, input bit gap);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'h5A5A;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
  endtask

  task automatic run(input int mode, input bit gaps, input bit have_prev);
    build(mode);
    for (int x = 0; x < NN; x++) begin
      beat(am[x], gaps && (x % 7 == 3));
      if (x == 0) begin
        #1;
        check(done == 1'b0, "R6 done cleared by new load", 64'(done), 64'd0);
      end
    end
    for (int x = 0; x < NN - 1; x++) beat(bm[x], gaps && (x % 5 == 2));
    // R4: mid-load, the previous results are untouched.
    @(negedge clk);
    in_valid = 1'b0;
    rd_addr  = AW'(5);
    @(negedge clk);
    if (have_prev)
      check(rd_data == prev_c5, "R4 old result kept during load",
            64'(rd_data), 64'(prev_c5));
    beat(bm[NN-1], 1'b0);
    // Edge E0 just accepted the last B element; m = edges since E0.
    for (int m = 0; m <= N*N*N + 2; m++) begin
      @(negedge clk);
      in_valid = (m < 40);     // R5: junk beats during computation
      in_data  = 16'hBEEF;
      if (m == N*N*N + 1)
        check(done == 1'b0, "R6 done not early", 64'(done), 64'd0);
      if (m == N*N*N + 2)
        check(done == 1'b1, "R6 done timing", 64'(done), 64'd1);
    end
    in_valid = 1'b0;
    // Drain in row-major order; the monitor compares (R3, R7, R2, R5).
    for (int x = 0; x < NN; x++) begin
      @(negedge clk);
      rd_addr = AW'(x);
      rd_req  = 1'b1;
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 all results drained",
          64'(exp_q.size()), 64'd0);
    check(done == 1'b1, "R6 done held while draining", 64'(done), 64'd1);
    prev_c5 = cm[5];
  endtask

  // Monitor side of the scoreboard.
  always @(posedge clk) pend <= rd_req;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read", 64'(rd_data), 64'd0);
      end else begin
        logic [ACC_W-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R3 result element", 64'(rd_data), 64'(e));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        check(rd_data == '0, "R1 rd_data after reset", 64'(rd_data), 64'd0);
        rst = 1'b0;
        run(0, 1'b1, 1'b0);   // pseudo-random operands, gapped stream (R2)
        run(1, 1'b0, 1'b1);   // all-ones operands, restart from done (R3, R6)
      end
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule